// File: doc/BRIEF.md
# Banked Interrupt Controller with Per-Source Trigger Selection

This block gathers interrupt sources that are organised in banks of 32. Each bank drives its own request line towards the processor. Every source is resynchronised to the local clock. Each source is then qualified by one of four trigger kinds: level active-high, level active-low, rising edge or falling edge. The qualified result is shown in a per-bank status word. Software controls each bank through a small memory-mapped register bus. Per bank it can enable sources, force them pending, acknowledge them and pick the trigger kind of each one.

A bank's request line is high whenever some source is both pending and enabled. For each bank the block also gives a dispatcher the index of the lowest-numbered pending enabled source, together with a valid flag. Software therefore does not have to scan the status word. Source number g lives in bank g >> 5 at bit g & 31.

Top module: `mbank_irqc`

## Requirements
- R1: After reset, every enable word reads 0 and every status word reads 0. Every polarity word reads 0xFFFFFFFF, every trigger-mode word reads 0, and all request lines and valid flags are low.
- R2: Bank n occupies byte addresses n*0x18 to n*0x18+0x17. Word offsets: 0x0 status (read only), 0x4 enable, 0x8 set, 0xC clear, 0x10 polarity, 0x14 trigger mode. Enable, polarity and mode read back what was written. Set and clear read as 0. A write to one bank's register changes no other bank.
- R3: With mode bit 0 and polarity bit 1, the status bit equals the source input two clock edges after the input changes.
- R4: With mode bit 0 and polarity bit 0, the status bit is the inverse of the input, with the same two-edge latency.
- R5: With mode bit 1 and polarity bit 1, a rising input edge sets the status bit on the third clock edge after the change. The bit then stays set after the input returns low.
- R6: With mode bit 1 and polarity bit 0, a falling input edge latches the status bit and a rising edge does not.
- R7: Writing 1 to a clear bit drops a latched pending bit at that write. Zero bits in the clear word change nothing. A level source whose input is still active stays pending after a clear.
- R8: Writing 1 to a set bit makes that source pending at that write, whatever its mode.
- R9: A bank's request line is high exactly when some bit is set in both its status and its enable word. Disabled sources still show in status.
- R10: A bank's valid flag equals its request line. The vector gives the lowest bit index that is both pending and enabled.
- R11: Source g is handled by bank g >> 5 at bit g & 31. Request line n belongs to bank n alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | NUM_BANKS*32 (160) | Asynchronous interrupt sources, bit g is source g |
| irq_out | output | NUM_BANKS (5) | One request line per bank |
| vec_id | output | NUM_BANKS*5 (25) | Lowest pending enabled index, 5 bits per bank |
| vec_ok | output | NUM_BANKS (5) | Vector valid per bank |

## Verification
A source change passes through two synchroniser stages. A level source's status, request and vector therefore follow on the second rising edge after the change. An edge source needs one more stage for the previous-sample register and latches on the third edge. Register writes, set and clear take effect at the edge that samples the strobe, and reads are combinational from registered state. The bench changes inputs just after a rising edge and counts edges explicitly. It checks one edge before each due edge, to show the result is not early, and then on the due edge, always sampling on the falling clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_PER_BANK = 32;
  localparam int IDX_W        = $clog2(SRC_PER_BANK);
  localparam int BANK_STRIDE  = 24;   // bytes per bank
  localparam int WORDS_PER_BANK = BANK_STRIDE / 4;
  localparam int SEL_W        = 3;

  typedef enum logic [SEL_W-1:0] {
    RG_STAT = 3'd0,
    RG_EN   = 3'd1,
    RG_SET  = 3'd2,
    RG_CLR  = 3'd3,
    RG_POL  = 3'd4,
    RG_EDGE = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] m1_q, m2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q <= '0;
      m2_q <= '0;
    end else begin
      m1_q <= d_i;
      m2_q <= m1_q;
    end
  end

  assign q_o = m2_q;
endmodule

// File: rtl/irqc_first.sv
module irqc_first #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic [IW-1:0] id_o,
  output logic          ok_o
);
  always_comb begin
    id_o = '0;
    ok_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        id_o = IW'(i);
        ok_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int W = SRC_PER_BANK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         hit_i,
  input  logic         we_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] status_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] setp_o,
  output logic [W-1:0] clrp_o
);
  logic [W-1:0] smp_w, prev_q;
  logic [W-1:0] en_q, en_d, pol_q, pol_d, edge_q, edge_d, lat_q, lat_d;
  logic [W-1:0] set_v, clr_v, rise_w, fall_w, evt_w, lvl_w;
  logic         wr_w, cfg_ce;

  irqc_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (smp_w)
  );

  assign wr_w   = hit_i & we_i;
  assign cfg_ce = wr_w & ((sel_i == RG_EN) | (sel_i == RG_POL) | (sel_i == RG_EDGE));

  // trigger qualification
  always_comb begin
    rise_w = smp_w & ~prev_q;
    fall_w = ~smp_w & prev_q;
    evt_w  = edge_q & ((pol_q & rise_w) | (~pol_q & fall_w));
    lvl_w  = ~edge_q & ~(smp_w ^ pol_q);
  end

  // next state
  always_comb begin
    en_d   = en_q;
    pol_d  = pol_q;
    edge_d = edge_q;
    set_v  = (wr_w && sel_i == RG_SET) ? wdata_i : '0;
    clr_v  = (wr_w && sel_i == RG_CLR) ? wdata_i : '0;
    if (cfg_ce) begin
      case (sel_i)
        RG_EN:   en_d   = wdata_i;
        RG_POL:  pol_d  = wdata_i;
        RG_EDGE: edge_d = wdata_i;
        default: ;
      endcase
    end
    lat_d = (lat_q & ~clr_v) | set_v | evt_w;
  end

  // configuration registers, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '1;
      edge_q <= '0;
    end else if (cfg_ce) begin
      en_q   <= en_d;
      pol_q  <= pol_d;
      edge_q <= edge_d;
    end
  end

  // pending latches and previous sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      prev_q <= '0;
    end else begin
      lat_q  <= lat_d;
      prev_q <= smp_w;
    end
  end

  assign status_o = lat_q | lvl_w;
  assign en_o     = en_q;
  assign edge_o   = edge_q;
  assign setp_o   = set_v;
  assign clrp_o   = clr_v;

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      case (sel_i)
        RG_STAT: rdata_o = status_o;
        RG_EN:   rdata_o = en_q;
        RG_POL:  rdata_o = pol_q;
        RG_EDGE: rdata_o = edge_q;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbank_irqc.sv
module mbank_irqc
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_we,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_in,
  output logic [NUM_BANKS-1:0]              irq_out,
  output logic [NUM_BANKS*IDX_W-1:0]        vec_id,
  output logic [NUM_BANKS-1:0]              vec_ok
);
  localparam int NSRC   = NUM_BANKS * SRC_PER_BANK;
  localparam int WADR_W = ADDR_W - 2;

  logic                   rst_i_n;
  logic [WADR_W-1:0]      word_w;
  logic                   aligned_w;
  logic [NSRC-1:0]        status_w, en_w, edge_w, setp_w, clrp_w;
  logic [NSRC-1:0]        rd_all;

  irqc_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_i_n)
  );

  assign word_w    = bus_addr[ADDR_W-1:2];
  assign aligned_w = (bus_addr[1:0] == 2'b00);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE_W = b * WORDS_PER_BANK;
    logic     hit;
    reg_sel_e sel;
    logic [SRC_PER_BANK-1:0] pend_en;

    assign hit = aligned_w && (word_w >= WADR_W'(BASE_W)) &&
                 (word_w < WADR_W'(BASE_W + WORDS_PER_BANK));
    assign sel = reg_sel_e'(SEL_W'(word_w - WADR_W'(BASE_W)));

    irqc_bank #(.W(SRC_PER_BANK)) u_bank (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .src_i    (src_in[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .hit_i    (hit),
      .we_i     (bus_we),
      .sel_i    (sel),
      .wdata_i  (bus_wdata),
      .rdata_o  (rd_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .status_o (status_w[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .en_o     (en_w[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .edge_o   (edge_w[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .setp_o   (setp_w[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .clrp_o   (clrp_w[b*SRC_PER_BANK +: SRC_PER_BANK])
    );

    assign pend_en    = status_w[b*SRC_PER_BANK +: SRC_PER_BANK] &
                        en_w[b*SRC_PER_BANK +: SRC_PER_BANK];
    assign irq_out[b] = |pend_en;

    irqc_first #(.W(SRC_PER_BANK), .IW(IDX_W)) u_first (
      .req_i (pend_en),
      .id_o  (vec_id[b*IDX_W +: IDX_W]),
      .ok_o  (vec_ok[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      bus_rdata = bus_rdata | rd_all[b*SRC_PER_BANK +: SRC_PER_BANK];
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int NB = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NB-1:0]              irq,
  input logic [NB-1:0]              ok,
  input logic [NB*IDX_W-1:0]        id,
  input logic [NB*SRC_PER_BANK-1:0] status,
  input logic [NB*SRC_PER_BANK-1:0] en,
  input logic [NB*SRC_PER_BANK-1:0] edgem,
  input logic [NB*SRC_PER_BANK-1:0] setp,
  input logic [NB*SRC_PER_BANK-1:0] clrp
);
  for (genvar b = 0; b < NB; b++) begin : g_chk
    logic [SRC_PER_BANK-1:0] st, en_b, ed, sp, cp, pe, below;
    logic [IDX_W-1:0]        ix;
    assign st    = status[b*SRC_PER_BANK +: SRC_PER_BANK];
    assign en_b  = en[b*SRC_PER_BANK +: SRC_PER_BANK];
    assign ed    = edgem[b*SRC_PER_BANK +: SRC_PER_BANK];
    assign sp    = setp[b*SRC_PER_BANK +: SRC_PER_BANK];
    assign cp    = clrp[b*SRC_PER_BANK +: SRC_PER_BANK];
    assign ix    = id[b*IDX_W +: IDX_W];
    assign pe    = st & en_b;
    assign below = (SRC_PER_BANK'(1) << ix) - SRC_PER_BANK'(1);

    // R10
    req_valid_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[b] == ok[b]);

    // R9
    no_enable_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_b == '0) |-> !irq[b]);

    // R10
    vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok[b] |-> (((pe >> ix) & SRC_PER_BANK'(1)) != '0) && ((pe & below) == '0));

    // R8
    set_forces_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp != '0) |=> ((st & $past(sp)) == $past(sp)));

    // R5
    edge_pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(st) & $past(ed) & ed & ~$past(cp)) & ~st) == '0);
  end
endmodule

bind mbank_irqc irqc_chk #(.NB(NUM_BANKS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq    (irq_out),
  .ok     (vec_ok),
  .id     (vec_id),
  .status (status_w),
  .en     (en_w),
  .edgem  (edge_w),
  .setp   (setp_w),
  .clrp   (clrp_w)
);

// File: tb/sim_mbank_irqc.sv
`timescale 1ns/1ps
module sim_mbank_irqc;
  localparam int NB = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NB*32-1:0] src_in;
  logic [NB-1:0] irq_out;
  logic [NB*5-1:0] vec_id;
  logic [NB-1:0] vec_ok;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq lines, 2 valid flags, 3 vector of bank
    int          bank;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mbank_irqc u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_out(irq_out), .vec_id(vec_id), .vec_ok(vec_ok)
  );

  function automatic logic [7:0] ra(int b, int off);
    return 8'(b * 24 + off);
  endfunction

  // monitor: compares queued expectations on the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = 32'(irq_out);
        2:       act = 32'(vec_ok);
        default: act = 32'(vec_id[it.bank*5 +: 5]);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic chk_rd(logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    bus_addr = a;
    it.kind = 0; it.bank = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_out(int kind, int bank, logic [31:0] e, string tag);
    item_t it;
    it.kind = kind; it.bank = bank; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; src_in = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk_rd(ra(0, 4),  32'h0,        "R1 enable b0");
    chk_rd(ra(2, 0),  32'h0,        "R1 status b2");
    chk_rd(ra(3, 16), 32'hFFFFFFFF, "R1 polarity b3");
    chk_rd(ra(4, 20), 32'h0,        "R1 mode b4");
    chk_out(1, 0, 32'h0, "R1 irq lines");
    chk_out(2, 0, 32'h0, "R1 valid flags");

    // R2 address map
    wr(ra(3, 4), 32'hA5A50001);
    chk_rd(ra(3, 4),  32'hA5A50001, "R2 enable readback b3");
    chk_rd(ra(2, 4),  32'h0,        "R2 neighbour enable b2");
    chk_rd(ra(3, 16), 32'hFFFFFFFF, "R2 polarity untouched b3");
    chk_rd(ra(3, 8),  32'h0,        "R2 set reads zero");
    chk_rd(ra(3, 12), 32'h0,        "R2 clear reads zero");
    wr(ra(3, 4), 32'h0);

    // R3 level high, two-edge latency
    wr(ra(0, 4), 32'h10);
    src_in[4] = 1'b1;
    tick(1);
    chk_rd(ra(0, 0), 32'h0,  "R3 not yet after one edge");
    tick(1);
    chk_rd(ra(0, 0), 32'h10, "R3 status follows input");
    chk_out(1, 0, 32'h01, "R9 enabled level raises line 0");
    src_in[4] = 1'b0;
    tick(2);
    chk_rd(ra(0, 0), 32'h0,  "R3 status drops with input");
    chk_out(1, 0, 32'h0,  "R9 line 0 drops");

    // R4 level low
    wr(ra(1, 16), 32'hFFFFFF7F);
    chk_rd(ra(1, 0), 32'h80, "R4 low input is active");
    src_in[39] = 1'b1;
    tick(2);
    chk_rd(ra(1, 0), 32'h0,  "R4 high input inactive");
    src_in[39] = 1'b0;
    tick(2);
    chk_rd(ra(1, 0), 32'h80, "R4 active again");
    wr(ra(1, 16), 32'hFFFFFFFF);
    chk_rd(ra(1, 0), 32'h0,  "R4 restored polarity");

    // R5 rising edge
    wr(ra(2, 20), 32'h1);
    src_in[64] = 1'b1;
    tick(2);
    chk_rd(ra(2, 0), 32'h0, "R5 not latched after two edges");
    tick(1);
    chk_rd(ra(2, 0), 32'h1, "R5 latched on third edge");
    src_in[64] = 1'b0;
    tick(3);
    chk_rd(ra(2, 0), 32'h1, "R5 held after input low");

    // R7 clear on edge source
    wr(ra(2, 12), 32'h0);
    chk_rd(ra(2, 0), 32'h1, "R7 zero clear has no effect");
    wr(ra(2, 12), 32'h1);
    chk_rd(ra(2, 0), 32'h0, "R7 clear drops edge pending");

    // R6 falling edge
    wr(ra(2, 20), 32'h3);
    wr(ra(2, 16), 32'hFFFFFFFD);
    src_in[65] = 1'b1;
    tick(3);
    chk_rd(ra(2, 0), 32'h0, "R6 rising edge ignored");
    src_in[65] = 1'b0;
    tick(3);
    chk_rd(ra(2, 0), 32'h2, "R6 falling edge latched");
    wr(ra(2, 12), 32'h2);
    chk_rd(ra(2, 0), 32'h0, "R7 clear falling pending");

    // R7 level source survives clear
    src_in[4] = 1'b1;
    tick(2);
    wr(ra(0, 12), 32'h10);
    chk_rd(ra(0, 0), 32'h10, "R7 active level stays pending");
    src_in[4] = 1'b0;
    tick(2);
    chk_rd(ra(0, 0), 32'h0,  "R7 level gone after input low");

    // R8 software set, R9 disabled visible, R10 lowest index
    wr(ra(4, 8), 32'h80000000);
    chk_rd(ra(4, 0), 32'h80000000, "R8 set forces pending");
    chk_out(1, 0, 32'h0, "R9 disabled pending gives no line");
    chk_out(2, 0, 32'h0, "R10 no valid while disabled");
    wr(ra(4, 4), 32'h80000008);
    chk_out(1, 0, 32'h10, "R9 line 4 after enable");
    chk_out(3, 4, 32'd31, "R10 vector 31");
    wr(ra(4, 8), 32'h8);
    chk_out(3, 4, 32'd3,  "R10 lower index wins");
    wr(ra(4, 12), 32'h8);
    chk_out(3, 4, 32'd31, "R10 back to 31 after clear");
    wr(ra(4, 12), 32'h80000000);
    chk_out(2, 0, 32'h0,  "R10 valid drops");
    chk_out(1, 0, 32'h0,  "R9 line 4 drops");

    // R10 partial enable in bank 1
    wr(ra(1, 8), 32'h00100200);
    wr(ra(1, 4), 32'h00100000);
    chk_out(3, 1, 32'd20, "R10 only enabled bit counts");
    wr(ra(1, 4), 32'h00100200);
    chk_out(3, 1, 32'd9,  "R10 lowest of two");
    chk_out(1, 0, 32'h02, "R11 only line 1 high");

    // R11 global source 130 -> bank 4 bit 2
    wr(ra(4, 4), 32'h4);
    src_in[130] = 1'b1;
    tick(2);
    chk_out(1, 0, 32'h12, "R11 line 4 from source 130");
    chk_rd(ra(4, 0), 32'h4, "R11 bank 4 bit 2 status");
    chk_out(3, 4, 32'd2,    "R11 vector bank 4");

    tick(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule